// File: doc/BRIEF.md
# Skewed Four-Bank Matrix Memory

This block holds a 4x4 matrix of 16-bit elements spread over four independent banks. Each bank has its own word address, so all four banks can be reached in the same cycle. A plain layout would put a whole column in one bank, which would turn every column access into four serial cycles. To avoid that, each row is rotated across the banks by its own row index. Any full row and any full column then touches each bank exactly once.

A caller selects row or column mode, gives an index and either writes four lanes or reads four lanes in one cycle. Lane k always carries the k-th element of the chosen row or column. An internal routing stage applies the rotation on writes and removes it on reads, so the caller never sees the skew. Read data is registered and appears on the cycle after the request.

Top module: `skew_matrix_mem`

## Requirements
- R1: While `rst_n` is low, every stored element becomes zero and `rd_lanes` is zero.
- R2: A read in row mode (`col_mode`=0) with `sel`=r puts element (r,k) on lane k of `rd_lanes` (bits k*16+15..k*16) one clock edge after the request.
- R3: A read in column mode (`col_mode`=1) with `sel`=c puts element (k,c) on lane k of `rd_lanes` one clock edge after the request.
- R4: A write in row mode with `sel`=r stores lane k of `wr_lanes` (bits k*16+15..k*16) as element (r,k), all four lanes in one cycle.
- R5: A write in column mode with `sel`=c stores lane k of `wr_lanes` as element (k,c), all four lanes in one cycle.
- R6: Element (r,c) is kept in bank (r+c) mod 4 at word r, so data written in either mode reads back at the same matrix position in the other mode.
- R7: A write cycle leaves `rd_lanes` unchanged at the following clock edge.
- R8: A read issued in the cycle right after a write returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_mode | input | 1 | 0 selects a row, 1 selects a column |
| sel | input | 2 | Row or column index, 0 to 3 |
| wr_en | input | 1 | 1 writes `wr_lanes`, 0 reads into `rd_lanes` |
| wr_lanes | input | 64 | Four 16-bit write lanes, lane k in bits k*16+15..k*16 |
| rd_lanes | output | 64 | Four 16-bit registered read lanes, same lane packing |

## Verification
The assertions assume that reset is held low at the first clock edge and that `col_mode`, `sel`, `wr_en` and `wr_lanes` carry known values on every edge after reset. They also assume that reset is not pulsed again in the middle of traffic, because the write and read checks look one edge back. The bench drives every input on the falling edge from tasks, holds reset over several edges at the start, and never releases it between operations. Its accesses cover all indices in both modes, including back-to-back write and read sequences that cross modes.

// File: rtl/skew_matrix_mem.sv
module skew_matrix_mem #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           col_mode,
  input  logic [1:0]     sel,
  input  logic           wr_en,
  input  logic [4*W-1:0] wr_lanes,
  output logic [4*W-1:0] rd_lanes
);
  localparam int N  = 4;
  localparam int AW = 2;

  logic [W-1:0]  bank    [N][N];
  logic [AW-1:0] addr    [N];
  logic [AW-1:0] lane_of [N];
  logic [AW-1:0] src     [N];
  logic [W-1:0]  rd_q    [N];

  for (genvar b = 0; b < N; b++) begin : g_bank
    assign addr[b]    = col_mode ? AW'(AW'(b) - sel) : sel;
    assign lane_of[b] = AW'(AW'(b) - sel);
  end

  for (genvar k = 0; k < N; k++) begin : g_lane
    assign src[k] = AW'(sel + AW'(k));
    assign rd_lanes[k*W +: W] = rd_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < N; b++)
        for (int a = 0; a < N; a++)
          bank[b][a] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < N; b++)
        bank[b][addr[b]] <= wr_lanes[int'(lane_of[b])*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) rd_q[k] <= '0;
    end else if (!wr_en) begin
      for (int k = 0; k < N; k++) rd_q[k] <= bank[src[k]][addr[src[k]]];
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> rd_lanes == '0);

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(rd_lanes));

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R4 and R5 land in the skewed slot of R6
    assert_place_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bank[AW'($past(sel) + AW'(k))][$past(col_mode) ? AW'(k) : $past(sel)]
                == $past(wr_lanes[k*W +: W]));
    // R3 uses the same lane rule in column mode
    assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> rd_lanes[k*W +: W]
                 == $past(bank[AW'(sel + AW'(k))][col_mode ? AW'(k) : sel]));
  end
endmodule

// File: tb/test_skew_matrix_mem.sv
`timescale 1ns/1ps
module test_skew_matrix_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        col_mode = 1'b0;
  logic [1:0]  sel = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_lanes = '0;
  logic [63:0] rd_lanes;

  logic [15:0] m [4][4];
  logic [63:0] exp_rd = '0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  skew_matrix_mem i_skew_matrix_mem (
    .clk(clk), .rst_n(rst_n), .col_mode(col_mode), .sel(sel),
    .wr_en(wr_en), .wr_lanes(wr_lanes), .rd_lanes(rd_lanes)
  );

  task automatic check(input string tag);
    checks++;
    if (rd_lanes !== exp_rd) begin
      failures++;
      $display("FAIL %s: rd_lanes=%h expected=%h", tag, rd_lanes, exp_rd);
    end
  endtask

  task automatic op(input bit cm, input logic [1:0] s, input bit we,
                    input logic [63:0] d, input string tag);
    @(negedge clk);
    col_mode = cm; sel = s; wr_en = we; wr_lanes = d;
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) begin
      if (we) begin
        if (cm) m[k][s] = d[k*16 +: 16];
        else    m[s][k] = d[k*16 +: 16];
      end else begin
        exp_rd[k*16 +: 16] = cm ? m[k][s] : m[s][k];
      end
    end
    check(tag);
  endtask

  function automatic logic [63:0] pat(input logic [15:0] base);
    return {base + 16'd3, base + 16'd2, base + 16'd1, base};
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) m[r][c] = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    for (int r = 0; r < 4; r++) op(1'b0, 2'(r), 1'b0, '0, "R1 cleared row");
    for (int c = 0; c < 4; c++) op(1'b1, 2'(c), 1'b0, '0, "R1 cleared col");

    for (int r = 0; r < 4; r++) op(1'b0, 2'(r), 1'b1, pat(16'(16'h0100 * (r + 1))), "R7 row write");
    for (int r = 0; r < 4; r++) op(1'b0, 2'(r), 1'b0, '0, "R2 R4 row read");
    for (int c = 0; c < 4; c++) op(1'b1, 2'(c), 1'b0, '0, "R3 R6 col read");

    op(1'b1, 2'd1, 1'b1, pat(16'hA000), "R7 col write");
    op(1'b1, 2'd1, 1'b0, '0, "R8 R5 col read after write");
    for (int r = 0; r < 4; r++) op(1'b0, 2'(r), 1'b0, '0, "R6 R5 row read");

    op(1'b0, 2'd3, 1'b1, pat(16'hC0DE), "R7 row write");
    op(1'b1, 2'd0, 1'b0, '0, "R8 R6 col read after row write");
    op(1'b1, 2'd3, 1'b1, pat(16'h5550), "R7 col write");
    op(1'b0, 2'd2, 1'b0, '0, "R8 R6 row read after col write");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = rnd();
      op(a[0], a[2:1], a[3], {rnd(), rnd()}, a[3] ? "R7 R4 R5 mixed write" : "R2 R3 mixed read");
    end
    for (int c = 0; c < 4; c++) op(1'b1, 2'(c), 1'b0, '0, "R3 R6 final col read");
    for (int r = 0; r < 4; r++) op(1'b0, 2'(r), 1'b0, '0, "R2 R6 final row read");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule